// File: doc/BRIEF.md
# SPI Flash Page Command Engine

This block carries out one SPI flash instruction at a time for a host, so software never has to toggle serial lines itself. The host loads a 256-byte page buffer through a simple byte port and writes a 32-bit configuration word. The low byte of that word is the instruction code and the upper three bytes are the page address, stored least significant byte highest. The host then pulses start. The engine drives SPI mode 0 with chip select held low for the whole instruction. It shifts out the opcode, then any address bytes, then the page data for a program. For a read it captures the returned bytes into the buffer. For a status read it keeps the one returned byte.

Two busy flags report progress. The instruction flag covers the whole chip-select window. The data flag covers only instructions that move a page. Each flag emits a one-cycle done pulse when it clears. A mode enable input decides whether the engine owns the SPI pins. When it is low the pins are released and start requests are not taken.

Top module: `spi_page_engine`

## Requirements
- R1: After reset, spi_cs_no is 1, spi_sck_o is 0, cmd_busy_o, data_busy_o, cmd_done_o and data_done_o are 0, and spi_oe_o is 0 while mode_en_i is 0.
- R2: Configuration word decode: bits 7:0 are the opcode, sent first. Then come address bits 23:16 (taken from word bits 15:8), address bits 15:8 (from word bits 23:16) and address bits 7:0 (from word bits 31:24). For example, 0x00FF3F02 sends 02, 3F, FF, 00.
- R3: SPI mode 0. SCK idles low whenever chip select is high. Each byte goes out MSB first. MOSI is stable while SCK is high. One SCK period is DIV system clocks. Chip select stays low from the first bit to the last.
- R4: A start pulse with mode_en_i=1 while idle raises cmd_busy_o and lowers chip select at the next edge. cmd_busy_o then stays high for exactly bytes×8×DIV cycles, and cmd_done_o pulses for one cycle in the first cycle it reads 0.
- R5: A start pulse that arrives while cmd_busy_o is 1 is dropped. It does not lengthen the busy time and does not change the bytes sent.
- R6: Opcode 0x02 (program) sends the opcode, three address bytes, then buffer bytes 0 to 255 in ascending order (260 bytes).
- R7: Opcode 0x03 (read) sends the opcode and three address bytes, then clocks in 256 bytes. These are stored at buffer indices 0 to 255 in arrival order and can be read back on buf_rdata_o.
- R8: Opcode 0x05 sends one byte and captures the next returned byte on status_o. Opcode 0x20 sends the opcode plus three address bytes. Any other opcode sends only the opcode byte.
- R9: data_busy_o is 1 only during opcodes 0x02 and 0x03, only while cmd_busy_o is 1, and clears together with it. data_done_o pulses for one cycle in the first cycle that data_busy_o reads 0.
- R10: With mode_en_i=0, spi_oe_o is 0 and start pulses are ignored.
- R11: Host writes to the page buffer are ignored while data_busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_en_i | input | 1 | Engine owns the SPI pins when 1 |
| cfg_we_i | input | 1 | Load configuration word |
| cfg_wdata_i | input | 32 | Configuration word (opcode, swapped address) |
| start_i | input | 1 | Start pulse for the configured instruction |
| buf_we_i | input | 1 | Host page buffer write strobe |
| buf_addr_i | input | AW | Host page buffer byte index |
| buf_wdata_i | input | 8 | Host page buffer write data |
| buf_rdata_o | output | 8 | Page buffer byte at buf_addr_i |
| cmd_busy_o | output | 1 | Instruction in progress |
| data_busy_o | output | 1 | Page data transfer in progress |
| cmd_done_o | output | 1 | One-cycle pulse when the instruction ends |
| data_done_o | output | 1 | One-cycle pulse when page data ends |
| status_o | output | 8 | Byte captured by the status read |
| spi_oe_o | output | 1 | Drive enable for the SPI pins |
| spi_sck_o | output | 1 | SPI clock |
| spi_cs_no | output | 1 | SPI chip select, active low |
| spi_mosi_o | output | 1 | SPI data out |
| spi_miso_i | input | 1 | SPI data in |

## Verification
On every cycle the assertions check several rules. SCK must be low while deselected, and MOSI must hold steady through each high SCK phase. An accepted start must lower chip select at once, and a disabled engine must stay idle. The data flag must stay inside the instruction flag, and each done pulse must line up with the fall of its flag. Some properties need a flash on the wire and a long stretch of time, so only the bench scenarios can show them. These are the exact busy length, the wire order of the swapped address bytes, ascending buffer order in both directions, the dropped second start, and the guarded host writes.

// File: rtl/spe_pkg.sv
package spe_pkg;
  typedef enum logic [2:0] {IC_PLAIN, IC_ERASE, IC_READ, IC_PROG, IC_STAT} icls_e;

  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_PROG  = 8'h02;
  localparam logic [7:0] OPC_ERASE = 8'h20;
  localparam logic [7:0] OPC_STAT  = 8'h05;

  function automatic icls_e classify(input logic [7:0] op);
    case (op)
      OPC_READ:  return IC_READ;
      OPC_PROG:  return IC_PROG;
      OPC_ERASE: return IC_ERASE;
      OPC_STAT:  return IC_STAT;
      default:   return IC_PLAIN;
    endcase
  endfunction

  function automatic logic has_addr(input icls_e c);
    return (c == IC_ERASE) || (c == IC_READ) || (c == IC_PROG);
  endfunction

  function automatic logic is_data(input icls_e c);
    return (c == IC_READ) || (c == IC_PROG);
  endfunction
endpackage

// File: rtl/spe_tick.sv
module spe_tick #(
  parameter int HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spe_page_buf.sv
module spe_page_buf #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk_i,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [7:0]    host_wdata_i,
  output logic [7:0]    host_rdata_o,
  input  logic          eng_we_i,
  input  logic [AW-1:0] eng_waddr_i,
  input  logic [7:0]    eng_wdata_i,
  input  logic [AW-1:0] eng_raddr_i,
  output logic [7:0]    eng_rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (eng_we_i)       mem_q[eng_waddr_i] <= eng_wdata_i;
    else if (host_we_i) mem_q[host_addr_i] <= host_wdata_i;
  end

  assign host_rdata_o = mem_q[host_addr_i];
  assign eng_rdata_o  = mem_q[eng_raddr_i];
endmodule

// File: rtl/spe_seq.sv
module spe_seq
  import spe_pkg::*;
#(
  parameter int PAGE = 256,
  parameter int AW   = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mode_en_i,
  input  logic [31:0]   cfg_i,
  input  logic          tick_i,
  output logic          run_o,
  input  logic          miso_i,
  output logic          sck_o,
  output logic          cs_no,
  output logic          mosi_o,
  output logic          cmd_busy_o,
  output logic          data_busy_o,
  output logic          cmd_done_o,
  output logic          data_done_o,
  output logic [7:0]    status_o,
  input  logic [7:0]    buf_rdata_i,
  output logic [AW-1:0] buf_raddr_o,
  output logic          buf_we_o,
  output logic [AW-1:0] buf_waddr_o,
  output logic [7:0]    buf_wdata_o
);
  localparam int BIW = $clog2(PAGE + 5);

  logic           active_q, cs_n_q, sck_q, dbusy_q, cdone_q, ddone_q;
  logic [2:0]     bit_cnt_q;
  logic [BIW-1:0] byte_idx_q, nxt_idx, last_idx;
  logic [7:0]     tx_sr_q, rx_sr_q, status_q, nxt_byte;
  logic [23:0]    addr_q;
  icls_e          cls_q;
  logic           accept, byte_end;

  assign accept   = start_i && mode_en_i && !active_q;
  assign nxt_idx  = byte_idx_q + 1'b1;
  assign byte_end = tick_i && sck_q && (bit_cnt_q == 3'd0);

  always_comb begin
    case (cls_q)
      IC_STAT:          last_idx = BIW'(1);
      IC_ERASE:         last_idx = BIW'(3);
      IC_READ, IC_PROG: last_idx = BIW'(PAGE + 3);
      default:          last_idx = '0;
    endcase
  end

  // byte to shift after the current one
  always_comb begin
    nxt_byte = 8'h00;
    if (has_addr(cls_q) && nxt_idx <= BIW'(3)) begin
      case (nxt_idx[1:0])
        2'd1:    nxt_byte = addr_q[23:16];
        2'd2:    nxt_byte = addr_q[15:8];
        default: nxt_byte = addr_q[7:0];
      endcase
    end else if (cls_q == IC_PROG) begin
      nxt_byte = buf_rdata_i;
    end
  end

  assign buf_raddr_o = AW'(nxt_idx - BIW'(4));
  assign buf_waddr_o = AW'(byte_idx_q - BIW'(4));
  assign buf_wdata_o = rx_sr_q;
  assign buf_we_o    = byte_end && (cls_q == IC_READ) && (byte_idx_q >= BIW'(4));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      cs_n_q     <= 1'b1;
      sck_q      <= 1'b0;
      dbusy_q    <= 1'b0;
      cdone_q    <= 1'b0;
      ddone_q    <= 1'b0;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      tx_sr_q    <= '0;
      rx_sr_q    <= '0;
      status_q   <= '0;
      addr_q     <= '0;
      cls_q      <= IC_PLAIN;
    end else begin
      cdone_q <= 1'b0;
      ddone_q <= 1'b0;
      if (accept) begin
        active_q   <= 1'b1;
        cs_n_q     <= 1'b0;
        sck_q      <= 1'b0;
        bit_cnt_q  <= 3'd7;
        byte_idx_q <= '0;
        tx_sr_q    <= cfg_i[7:0];
        cls_q      <= classify(cfg_i[7:0]);
        addr_q     <= {cfg_i[15:8], cfg_i[23:16], cfg_i[31:24]};
        dbusy_q    <= is_data(classify(cfg_i[7:0]));
      end else if (tick_i) begin
        if (!sck_q) begin
          sck_q   <= 1'b1;
          rx_sr_q <= {rx_sr_q[6:0], miso_i};
        end else begin
          sck_q <= 1'b0;
          if (bit_cnt_q != 3'd0) begin
            bit_cnt_q <= bit_cnt_q - 1'b1;
            tx_sr_q   <= {tx_sr_q[6:0], 1'b0};
          end else begin
            if (cls_q == IC_STAT && byte_idx_q == BIW'(1)) status_q <= rx_sr_q;
            if (byte_idx_q == last_idx) begin
              active_q <= 1'b0;
              cs_n_q   <= 1'b1;
              dbusy_q  <= 1'b0;
              cdone_q  <= 1'b1;
              ddone_q  <= dbusy_q;
            end else begin
              byte_idx_q <= nxt_idx;
              bit_cnt_q  <= 3'd7;
              tx_sr_q    <= nxt_byte;
            end
          end
        end
      end
    end
  end

  assign run_o       = active_q;
  assign sck_o       = sck_q;
  assign cs_no       = cs_n_q;
  assign mosi_o      = tx_sr_q[7];
  assign cmd_busy_o  = active_q;
  assign data_busy_o = dbusy_q;
  assign cmd_done_o  = cdone_q;
  assign data_done_o = ddone_q;
  assign status_o    = status_q;
endmodule

// File: rtl/spi_page_engine.sv
module spi_page_engine #(
  parameter int PAGE_BYTES = 256,
  parameter int DIV        = 4,
  parameter int AW         = $clog2(PAGE_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_en_i,
  input  logic          cfg_we_i,
  input  logic [31:0]   cfg_wdata_i,
  input  logic          start_i,
  input  logic          buf_we_i,
  input  logic [AW-1:0] buf_addr_i,
  input  logic [7:0]    buf_wdata_i,
  output logic [7:0]    buf_rdata_o,
  output logic          cmd_busy_o,
  output logic          data_busy_o,
  output logic          cmd_done_o,
  output logic          data_done_o,
  output logic [7:0]    status_o,
  output logic          spi_oe_o,
  output logic          spi_sck_o,
  output logic          spi_cs_no,
  output logic          spi_mosi_o,
  input  logic          spi_miso_i
);
  localparam int HALF = DIV / 2;

  logic [31:0]   cfg_q;
  logic          run, tick, eng_we;
  logic [AW-1:0] eng_raddr, eng_waddr;
  logic [7:0]    eng_rdata, eng_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_wdata_i;
  end

  spe_tick #(.HALF(HALF)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  spe_page_buf #(.DEPTH(PAGE_BYTES), .AW(AW)) u_buf (
    .clk_i       (clk_i),
    .host_we_i   (buf_we_i && !data_busy_o),
    .host_addr_i (buf_addr_i),
    .host_wdata_i(buf_wdata_i),
    .host_rdata_o(buf_rdata_o),
    .eng_we_i    (eng_we),
    .eng_waddr_i (eng_waddr),
    .eng_wdata_i (eng_wdata),
    .eng_raddr_i (eng_raddr),
    .eng_rdata_o (eng_rdata)
  );

  spe_seq #(.PAGE(PAGE_BYTES), .AW(AW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mode_en_i  (mode_en_i),
    .cfg_i      (cfg_q),
    .tick_i     (tick),
    .run_o      (run),
    .miso_i     (spi_miso_i),
    .sck_o      (spi_sck_o),
    .cs_no      (spi_cs_no),
    .mosi_o     (spi_mosi_o),
    .cmd_busy_o (cmd_busy_o),
    .data_busy_o(data_busy_o),
    .cmd_done_o (cmd_done_o),
    .data_done_o(data_done_o),
    .status_o   (status_o),
    .buf_rdata_i(eng_rdata),
    .buf_raddr_o(eng_raddr),
    .buf_we_o   (eng_we),
    .buf_waddr_o(eng_waddr),
    .buf_wdata_o(eng_wdata)
  );

  assign spi_oe_o = mode_en_i;
endmodule

// File: rtl/spe_checker.sv
module spe_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic mode_en_i,
  input logic start_i,
  input logic cmd_busy_o,
  input logic data_busy_o,
  input logic cmd_done_o,
  input logic data_done_o,
  input logic spi_sck_o,
  input logic spi_cs_no,
  input logic spi_mosi_o
);
  p_sck_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o);

  p_mosi_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_sck_o && $past(spi_sck_o)) |-> $stable(spi_mosi_o));

  p_start_take_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_en_i && !cmd_busy_o) |=> (cmd_busy_o && !spi_cs_no));

  p_cmd_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cmd_busy_o) |-> cmd_done_o);

  p_done_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_o |-> !cmd_busy_o);

  p_data_inside_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_busy_o |-> cmd_busy_o);

  p_data_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(data_busy_o) |-> data_done_o);

  p_off_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_en_i && !cmd_busy_o) |=> !cmd_busy_o);
endmodule

bind spi_page_engine spe_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_en_i  (mode_en_i),
  .start_i    (start_i),
  .cmd_busy_o (cmd_busy_o),
  .data_busy_o(data_busy_o),
  .cmd_done_o (cmd_done_o),
  .data_done_o(data_done_o),
  .spi_sck_o  (spi_sck_o),
  .spi_cs_no  (spi_cs_no),
  .spi_mosi_o (spi_mosi_o)
);

// File: tb/spi_page_engine_tb_top.sv
`timescale 1ns/1ps
module spi_page_engine_tb_top;
  localparam int DIV = 4;
  localparam int PG  = 256;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mode_en = 1'b0, cfg_we = 1'b0, start = 1'b0, buf_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0] buf_addr = '0, buf_wdata = '0;
  logic [7:0] buf_rdata, status;
  logic cmd_busy, data_busy, cmd_done, data_done, oe, sck, cs_n, mosi, miso;

  always #2.5 clk = ~clk;

  spi_page_engine #(.PAGE_BYTES(PG), .DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mode_en_i(mode_en),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .start_i(start),
    .buf_we_i(buf_we), .buf_addr_i(buf_addr), .buf_wdata_i(buf_wdata),
    .buf_rdata_o(buf_rdata), .cmd_busy_o(cmd_busy), .data_busy_o(data_busy),
    .cmd_done_o(cmd_done), .data_done_o(data_done), .status_o(status),
    .spi_oe_o(oe), .spi_sck_o(sck), .spi_cs_no(cs_n), .spi_mosi_o(mosi),
    .spi_miso_i(miso)
  );

  int checks = 0, fails = 0, cyc = 0, ddone_cnt = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // flash responder
  logic [7:0] rxq[$];
  logic [7:0] cur_b = '0, resp_op = '0;
  int bitc = 0;
  realtime last_rise = 0, sck_per = 0;

  function automatic logic resp_bit(input int bc, input logic [7:0] op);
    int bi = bc / 8;
    logic [7:0] b = 8'h00;
    if (op == 8'h05 && bi >= 1) b = 8'h5C;
    else if (op == 8'h03 && bi >= 4) b = 8'((bi - 4) * 5 + 3);
    return b[7 - (bc % 8)];
  endfunction

  assign miso = resp_bit(bitc, resp_op);

  always @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      bitc = 0;
      resp_op = 8'h00;
    end else begin
      if (last_rise > 0) sck_per = $realtime - last_rise;
      last_rise = $realtime;
      cur_b = {cur_b[6:0], mosi};
      if (bitc % 8 == 7) begin
        rxq.push_back(cur_b);
        if (bitc == 7) resp_op = cur_b;
      end
      bitc = bitc + 1;
    end
  end

  // reference model, updated each edge, compared each negedge
  int rem = 0;
  bit dflag = 0, e_cdone = 0, e_ddone = 0;
  logic [31:0] m_cfg = '0;

  function automatic int len_of(input logic [7:0] op);
    case (op)
      8'h03, 8'h02: return PG + 4;
      8'h20:        return 4;
      8'h05:        return 2;
      default:      return 1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rem = 0; dflag = 0; e_cdone = 0; e_ddone = 0; m_cfg = '0;
    end else begin
      e_cdone = (rem == 1);
      e_ddone = (rem == 1) && dflag;
      if (rem > 0) rem = rem - 1;
      else if (start && mode_en) begin
        rem = len_of(m_cfg[7:0]) * 8 * DIV;
        dflag = (m_cfg[7:0] == 8'h02) || (m_cfg[7:0] == 8'h03);
      end
      if (cfg_we) m_cfg = cfg_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      chk(cmd_busy == (rem > 0), "R4 busy model", cmd_busy, rem > 0);
      chk(data_busy == (rem > 0 && dflag), "R9 data busy model", data_busy, rem > 0 && dflag);
      chk(cmd_done == e_cdone, "R4 cmd done pulse", cmd_done, e_cdone);
      chk(data_done == e_ddone, "R9 data done pulse", data_done, e_ddone);
      if (data_done) ddone_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [31:0] w);
    @(negedge clk); cfg_we = 1; cfg_wdata = w;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    while (cmd_busy) @(negedge clk);
    step(2);
  endtask

  task automatic host_wr(input int a, input logic [7:0] d);
    @(negedge clk); buf_we = 1; buf_addr = 8'(a); buf_wdata = d;
    @(negedge clk); buf_we = 0;
  endtask

  initial begin
    step(3);
    chk(cs_n === 1'b1 && sck === 1'b0, "R1 pins idle", {cs_n, sck}, 2'b10);
    chk(cmd_busy === 1'b0 && data_busy === 1'b0, "R1 busy clear", {cmd_busy, data_busy}, 0);
    chk(oe === 1'b0, "R1 oe low", oe, 0);
    @(negedge clk); rst_ni = 1;
    step(2);

    // R10: disabled engine ignores start
    set_cfg(32'h0000_0006);
    rxq.delete();
    pulse_start(); step(6);
    chk(cmd_busy == 0 && oe == 0, "R10 start ignored when off", {cmd_busy, oe}, 0);
    chk(rxq.size() == 0, "R10 no bytes sent", rxq.size(), 0);

    mode_en = 1; step(1);
    chk(oe == 1, "R10 oe follows enable", oe, 1);

    // R8: opcode-only instruction
    rxq.delete(); pulse_start(); wait_idle();
    chk(rxq.size() == 1 && rxq[0] == 8'h06, "R8 opcode only", rxq.size(), 1);

    // R8: status read
    set_cfg(32'h0000_0005);
    rxq.delete(); pulse_start(); wait_idle();
    chk(rxq.size() == 2 && rxq[0] == 8'h05, "R8 status frame", rxq.size(), 2);
    chk(status == 8'h5C, "R8 status byte", status, 8'h5C);
    chk(sck_per == DIV * 5.0, "R3 sck period", longint'(sck_per), DIV * 5);

    // R2/R8: erase at 0x123400 -> word 0x00341220
    set_cfg(32'h0034_1220);
    rxq.delete(); pulse_start(); wait_idle();
    chk(rxq.size() == 4, "R8 erase length", rxq.size(), 4);
    chk({rxq[0], rxq[1], rxq[2], rxq[3]} == 32'h2012_3400, "R2 erase address order",
        {rxq[0], rxq[1], rxq[2], rxq[3]}, 32'h2012_3400);

    // R6: program top page 0x3FFF00
    for (int i = 0; i < PG; i++) host_wr(i, 8'(i * 7 + 1));
    set_cfg(32'h00FF_3F02);
    rxq.delete(); pulse_start();
    step(100);
    pulse_start();                 // R5: dropped while busy
    host_wr(5, 8'hEE);             // R11: ignored during data phase
    wait_idle();
    chk(rxq.size() == PG + 4, "R5 R6 program length", rxq.size(), PG + 4);
    chk({rxq[0], rxq[1], rxq[2], rxq[3]} == 32'h023F_FF00, "R2 program header",
        {rxq[0], rxq[1], rxq[2], rxq[3]}, 32'h023F_FF00);
    for (int i = 0; i < PG; i++)
      if (rxq[i + 4] != 8'(i * 7 + 1))
        chk(0, "R6 program data order", rxq[i + 4], 8'(i * 7 + 1));
    chk(1, "R6 program data scanned", 0, 0);
    @(negedge clk); buf_addr = 8'd5; #1;
    chk(buf_rdata == 8'(5 * 7 + 1), "R11 host write blocked", buf_rdata, 8'(5 * 7 + 1));

    // R7: read page 0x000100 -> word 0x00010003
    set_cfg(32'h0001_0003);
    rxq.delete(); pulse_start(); wait_idle();
    chk({rxq[0], rxq[1], rxq[2], rxq[3]} == 32'h0300_0100, "R2 read header",
        {rxq[0], rxq[1], rxq[2], rxq[3]}, 32'h0300_0100);
    for (int i = 0; i < PG; i++) begin
      @(negedge clk); buf_addr = 8'(i); #1;
      if (buf_rdata != 8'(i * 5 + 3))
        chk(0, "R7 read data stored", buf_rdata, 8'(i * 5 + 3));
    end
    chk(1, "R7 read data scanned", 0, 0);
    chk(ddone_cnt == 2, "R9 data done count", ddone_cnt, 2);

    // R11: host writes accepted again when idle
    host_wr(9, 8'h77);
    @(negedge clk); buf_addr = 8'd9; #1;
    chk(buf_rdata == 8'h77, "R11 host write when idle", buf_rdata, 8'h77);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule